// File: doc/BRIEF.md
# External Cache Controller with Address-Strobe Gating

This block sits between a processor bus and a system bus and fronts a small direct-mapped cache. Each processor access is latched and looked up in a tag store. A settle timer keeps the hit or miss result away from the termination output until the compare has had time to resolve. A read hit is ended locally with a one-cycle synchronous termination pulse, and the cached word is returned. The system bus never sees that access.

A miss, and every write, is passed to the system bus by raising the system strobe. This happens only after the decision has settled, so the system bus never sees a strobe that is later withdrawn. A read miss fills the line from the system read data and then terminates the processor cycle. A global invalidate input clears the valid bits one line per clock. Processor accesses wait while the clear runs.

An optional early mode terminates reads speculatively, before the decision is final. If such a read turns out to be a miss, bus error and halt are raised together. They stay high until the processor drops its strobe. The retried access is then sent straight to the system bus as a miss and fills the line.

Top module: `xcache_ctrl`

## Requirements
- R1: After reset all outputs are low and every line is invalid, so the first read of any address is a miss.
- R2: In normal mode a read hit raises `cpu_term` exactly DEC_LAT+1 clock edges after the first edge that samples `cpu_as` high, and never earlier.
- R3: On a read hit, `sys_as` stays low for the whole access, and `cpu_rdata` carries the stored word while `cpu_term` is high.
- R4: `sys_as` never rises before the decision has settled. For a normal miss it first appears DEC_LAT+1 edges after the strobe is sampled.
- R5: On a read miss, `sys_as` is held until `sys_ack`. The line is then written with tag, valid bit and `sys_rdata`, and `cpu_term` follows one cycle later carrying that data. A later read of the same address hits.
- R6: Writes always go to the system bus with `sys_wr` high and the processor address and data. A write hit also updates the cached word. A write miss allocates nothing, so a following read of that address misses.
- R7: An `inv_all` pulse sampled while idle clears all LINES lines, one per clock. It takes priority over a new access. No termination and no system strobe occur until the clear ends, and previously cached addresses then miss.
- R8: With `early_en` high, a read gets `cpu_term` EARLY_LAT edges after the strobe is sampled, before the decision. A speculative read hit causes no system strobe. Writes are never terminated speculatively: their `cpu_term` comes only after `sys_ack`.
- R9: In early mode a read miss raises `cpu_berr` and `cpu_halt` together at edge DEC_LAT+1. Both stay high while `cpu_as` is high and drop together after `cpu_as` is sampled low.
- R10: The access that follows a retry skips the decision wait. It raises `sys_as` on the first edge, fills the line, and terminates with the system data.
- R11: The index is address bits [OFF_W+IDX_W-1:OFF_W], where OFF_W = log2(DATA_W/8) and IDX_W = log2(LINES). The tag is the bits above the index. Two addresses with the same index and different tags evict each other, and lines with other indices are unaffected.
- R12: `cpu_term` is a single-cycle pulse per access. After it, the controller waits for `cpu_as` to be sampled low before it accepts a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| early_en | input | 1 | Speculative-termination mode, changed only while idle |
| inv_all | input | 1 | Pulse that clears every valid bit |
| cpu_as | input | 1 | Processor address strobe, held for the access |
| cpu_wr | input | 1 | Processor access is a write |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_term | output | 1 | Synchronous cycle termination pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_term` on reads |
| cpu_berr | output | 1 | Bus error for retry |
| cpu_halt | output | 1 | Halt for retry, paired with `cpu_berr` |
| sys_as | output | 1 | Gated address strobe toward the system bus |
| sys_wr | output | 1 | System access is a write |
| sys_addr | output | ADDR_W | System address |
| sys_wdata | output | DATA_W | System write data |
| sys_ack | input | 1 | System access complete |
| sys_rdata | input | DATA_W | System read data, valid with `sys_ack` |

## Verification
A wrong tag, a wrong valid bit or a wrong index shows on the very access that uses the line. A hit that should be a miss makes `sys_as` appear, or fail to appear, DEC_LAT+1 edges after the strobe, or puts stale data on `cpu_rdata` at termination. A timer that is off by one moves `cpu_term` or `sys_as` by a cycle, which an every-clock comparison against a behavioural model catches at once. An unfinished clear or a lost retry flag shows as an unexpected hit on the next access, or as a retried access that waits for a decision it should skip.

// File: rtl/xcache_pkg.sv
package xcache_pkg;

  typedef enum logic [2:0] {
    XC_IDLE,
    XC_CLEAR,
    XC_DECIDE,
    XC_HIT,
    XC_SYS,
    XC_DONE,
    XC_WAITNEG,
    XC_RETRY
  } xc_state_e;

endpackage

// File: rtl/xcache_settle.sv
// Decision settle timer: runs DEC_LAT cycles after start and flags the
// speculative termination point and the settled point.
module xcache_settle #(
  parameter int DEC_LAT   = 3,
  parameter int EARLY_LAT = 1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic start,
  output logic early_tick,
  output logic settled
);
  localparam int CNT_W = $clog2(DEC_LAT + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(DEC_LAT - 1);
  localparam logic [CNT_W-1:0] SPECP = CNT_W'(EARLY_LAT - 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      if (cnt_q == LAST) run_d = 1'b0;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign early_tick = run_q && (cnt_q == SPECP);
  assign settled    = run_q && (cnt_q == LAST);

  assert_timer_bounded_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    run_q |-> (cnt_q <= LAST));
  assert_timer_restart_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    start |=> (run_q && cnt_q == '0));

endmodule

// File: rtl/xcache_lines.sv
// Direct-mapped line store: valid bits with reset, tag and data words,
// fill, write-hit update and a one-line-per-clock global clear.
module xcache_lines #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 12,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              fill_en,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              clr_start,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              clr_busy,
  output logic              clr_last
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(LINES - 1);

  logic [LINES-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic              clr_busy_q, clr_busy_d;
  logic [IDX_W-1:0]  clr_ptr_q, clr_ptr_d;

  always_comb begin
    valid_d    = valid_q;
    clr_busy_d = clr_busy_q;
    clr_ptr_d  = clr_ptr_q;
    if (fill_en) valid_d[lk_idx] = 1'b1;
    if (clr_start) begin
      clr_busy_d = 1'b1;
      clr_ptr_d  = '0;
    end else if (clr_busy_q) begin
      valid_d[clr_ptr_q] = 1'b0;
      if (clr_ptr_q == TOP) clr_busy_d = 1'b0;
      else                  clr_ptr_d  = clr_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      clr_busy_q <= 1'b0;
      clr_ptr_q  <= '0;
    end else begin
      valid_q    <= valid_d;
      clr_busy_q <= clr_busy_d;
      clr_ptr_q  <= clr_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[lk_idx]  <= lk_tag;
      data_q[lk_idx] <= fill_data;
    end else if (upd_en) begin
      data_q[lk_idx] <= upd_data;
    end
  end

  assign lk_hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_data  = data_q[lk_idx];
  assign clr_busy = clr_busy_q;
  assign clr_last = clr_busy_q && (clr_ptr_q == TOP);

  assert_fill_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    fill_en |=> valid_q[$past(lk_idx)]);
  assert_clear_drops_line_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_busy_q && !clr_start) |=> !valid_q[$past(clr_ptr_q)]);

endmodule

// File: rtl/xcache_ctrl.sv
// Cache controller top: access sequencing, strobe gating and retry.
module xcache_ctrl
  import xcache_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int LINES     = 8,
  parameter int DEC_LAT   = 3,
  parameter int EARLY_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              early_en,
  input  logic              inv_all,
  input  logic              cpu_as,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_term,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_berr,
  output logic              cpu_halt,
  output logic              sys_as,
  output logic              sys_wr,
  output logic [ADDR_W-1:0] sys_addr,
  output logic [DATA_W-1:0] sys_wdata,
  input  logic              sys_ack,
  input  logic [DATA_W-1:0] sys_rdata
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  xc_state_e         state_q, state_d;
  logic              retry_q, retry_d;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              latch_en;

  logic              tmr_start, tmr_early, tmr_settled;
  logic              fill_en, upd_en, clr_start;
  logic              tg_hit, tg_clr_busy, tg_clr_last;
  logic [DATA_W-1:0] tg_data;

  xcache_settle #(
    .DEC_LAT  (DEC_LAT),
    .EARLY_LAT(EARLY_LAT)
  ) settle_i (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .start     (tmr_start),
    .early_tick(tmr_early),
    .settled   (tmr_settled)
  );

  xcache_lines #(
    .LINES (LINES),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) lines_i (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .lk_idx   (addr_q[OFF_W +: IDX_W]),
    .lk_tag   (addr_q[ADDR_W-1 -: TAG_W]),
    .fill_en  (fill_en),
    .fill_data(sys_rdata),
    .upd_en   (upd_en),
    .upd_data (wdata_q),
    .clr_start(clr_start),
    .lk_hit   (tg_hit),
    .lk_data  (tg_data),
    .clr_busy (tg_clr_busy),
    .clr_last (tg_clr_last)
  );

  // Next-state logic.
  always_comb begin
    state_d   = state_q;
    retry_d   = retry_q;
    latch_en  = 1'b0;
    tmr_start = 1'b0;
    clr_start = 1'b0;
    fill_en   = 1'b0;
    upd_en    = 1'b0;
    unique case (state_q)
      XC_IDLE: begin
        if (inv_all) begin
          clr_start = 1'b1;
          state_d   = XC_CLEAR;
        end else if (cpu_as) begin
          latch_en = 1'b1;
          if (retry_q) begin
            retry_d = 1'b0;
            state_d = XC_SYS;
          end else begin
            tmr_start = 1'b1;
            state_d   = XC_DECIDE;
          end
        end
      end
      XC_CLEAR: if (tg_clr_last) state_d = XC_IDLE;
      XC_DECIDE: begin
        if (tmr_settled) begin
          if (wr_q) begin
            upd_en  = tg_hit;
            state_d = XC_SYS;
          end else if (tg_hit) begin
            state_d = early_en ? XC_WAITNEG : XC_HIT;
          end else begin
            state_d = early_en ? XC_RETRY : XC_SYS;
          end
        end
      end
      XC_SYS: begin
        if (sys_ack) begin
          fill_en = !wr_q;
          state_d = XC_DONE;
        end
      end
      XC_HIT, XC_DONE: state_d = XC_WAITNEG;
      XC_WAITNEG: if (!cpu_as) state_d = XC_IDLE;
      XC_RETRY: begin
        if (!cpu_as) begin
          retry_d = 1'b1;
          state_d = XC_IDLE;
        end
      end
      default: state_d = XC_IDLE;
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XC_IDLE;
      retry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      retry_q <= retry_d;
    end
  end

  // Access latch with clock enable.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (latch_en) begin
      addr_q  <= cpu_addr;
      wr_q    <= cpu_wr;
      wdata_q <= cpu_wdata;
    end
  end

  // Outputs decoded from registered state.
  always_comb begin
    cpu_term  = (state_q == XC_HIT) || (state_q == XC_DONE) ||
                ((state_q == XC_DECIDE) && early_en && !wr_q && tmr_early);
    cpu_rdata = (cpu_term && !wr_q) ? tg_data : '0;
    cpu_berr  = (state_q == XC_RETRY);
    cpu_halt  = (state_q == XC_RETRY);
    sys_as    = (state_q == XC_SYS);
    sys_wr    = sys_as && wr_q;
    sys_addr  = sys_as ? addr_q : '0;
    sys_wdata = (sys_as && wr_q) ? wdata_q : '0;
  end

  assert_hit_after_settle_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == XC_HIT) |-> $past(tmr_settled));
  assert_hit_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    ((state_q == XC_DECIDE) && tmr_settled && tg_hit && !wr_q) |=> !sys_as);
  assert_strobe_after_decision_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(sys_as) |-> ($past(tmr_settled) || $past(retry_q)));
  assert_strobe_held_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (sys_as && !sys_ack) |=> sys_as);
  assert_clear_stalls_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    tg_clr_busy |-> (!cpu_term && !sys_as));
  assert_retry_held_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (cpu_berr && cpu_as) |=> (cpu_berr && cpu_halt));
  assert_term_single_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (cpu_term && !early_en) |=> !cpu_term);

endmodule

// File: tb/xcache_ctrl_tb.sv
module xcache_ctrl_tb_top;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 16;
  localparam int LINES     = 8;
  localparam int DEC_LAT   = 3;
  localparam int EARLY_LAT = 1;
  localparam int OFF       = 1;
  localparam int IDXW      = 3;
  localparam int SYS_WAIT  = 2;

  localparam int P_IDLE = 0, P_CLR = 1, P_DEC = 2, P_HIT = 3,
                 P_SYS = 4, P_DONE = 5, P_END = 6, P_RTY = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic early_en, inv_all, cpu_as, cpu_wr, sys_ack;
  logic [ADDR_W-1:0] cpu_addr;
  logic [DATA_W-1:0] cpu_wdata, sys_rdata;
  logic cpu_term, cpu_berr, cpu_halt, sys_as, sys_wr;
  logic [DATA_W-1:0] cpu_rdata, sys_wdata;
  logic [ADDR_W-1:0] sys_addr;

  int n_chk = 0;
  int n_fail = 0;
  int wd = 0;
  int wcnt = 0;

  always #10 clk = ~clk;

  xcache_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES),
    .DEC_LAT(DEC_LAT), .EARLY_LAT(EARLY_LAT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .early_en(early_en), .inv_all(inv_all),
    .cpu_as(cpu_as), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_term(cpu_term), .cpu_rdata(cpu_rdata), .cpu_berr(cpu_berr), .cpu_halt(cpu_halt),
    .sys_as(sys_as), .sys_wr(sys_wr), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
    .sys_ack(sys_ack), .sys_rdata(sys_rdata)
  );

  function automatic logic [15:0] pat(input logic [15:0] a);
    return a * 16'd5 + 16'h1234;
  endfunction
  function automatic int f_idx(input logic [15:0] a);
    return int'(a >> OFF) % LINES;
  endfunction
  function automatic logic [15:0] f_tag(input logic [15:0] a);
    return a >> (OFF + IDXW);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge.
  int          mst, mcnt;
  logic [15:0] ma, mwd;
  bit          mw, mretry;
  bit          m_valid [LINES];
  bit          m_known [LINES];
  logic [15:0] m_tag   [LINES];
  logic [15:0] m_data  [LINES];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = P_IDLE; mcnt = 0; mretry = 0; ma = 0; mw = 0; mwd = 0;
      for (int i = 0; i < LINES; i++) begin
        m_valid[i] = 0; m_known[i] = 0; m_tag[i] = 0; m_data[i] = 0;
      end
    end else begin
      case (mst)
        P_IDLE: begin
          if (inv_all) begin mst = P_CLR; mcnt = 0; end
          else if (cpu_as) begin
            ma = cpu_addr; mw = cpu_wr; mwd = cpu_wdata;
            if (mretry) begin mretry = 0; mst = P_SYS; end
            else begin mst = P_DEC; mcnt = 0; end
          end
        end
        P_CLR: begin
          m_valid[mcnt] = 0;
          if (mcnt == LINES - 1) mst = P_IDLE; else mcnt++;
        end
        P_DEC: begin
          if (mcnt == DEC_LAT - 1) begin
            bit hit;
            hit = m_valid[f_idx(ma)] && (m_tag[f_idx(ma)] == f_tag(ma));
            if (mw) begin
              if (hit) m_data[f_idx(ma)] = mwd;
              mst = P_SYS;
            end else if (hit) mst = early_en ? P_END : P_HIT;
            else mst = early_en ? P_RTY : P_SYS;
          end else mcnt++;
        end
        P_SYS: begin
          if (sys_ack) begin
            if (!mw) begin
              m_valid[f_idx(ma)] = 1; m_known[f_idx(ma)] = 1;
              m_tag[f_idx(ma)] = f_tag(ma); m_data[f_idx(ma)] = sys_rdata;
            end
            mst = P_DONE;
          end
        end
        P_HIT, P_DONE: mst = P_END;
        P_END: if (!cpu_as) mst = P_IDLE;
        P_RTY: if (!cpu_as) begin mretry = 1; mst = P_IDLE; end
        default: mst = P_IDLE;
      endcase
    end
  end

  // Every-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_term, e_sys;
      e_term = (mst == P_HIT) || (mst == P_DONE) ||
               ((mst == P_DEC) && early_en && !mw && (mcnt == EARLY_LAT - 1));
      e_sys  = (mst == P_SYS);
      chk(cpu_term == e_term, "R2", "cpu_term", cpu_term, e_term);
      chk(sys_as == e_sys, "R4", "sys_as", sys_as, e_sys);
      chk(sys_wr == (e_sys && mw), "R6", "sys_wr", sys_wr, e_sys && mw);
      chk(sys_addr == (e_sys ? ma : 16'h0), "R6", "sys_addr", sys_addr, e_sys ? ma : 16'h0);
      chk(sys_wdata == ((e_sys && mw) ? mwd : 16'h0), "R6", "sys_wdata", sys_wdata,
          (e_sys && mw) ? mwd : 16'h0);
      chk((cpu_berr == (mst == P_RTY)) && (cpu_halt == (mst == P_RTY)), "R9", "berr_halt",
          {cpu_berr, cpu_halt}, {2{mst == P_RTY}});
      if (e_term && !mw && m_known[f_idx(ma)])
        chk(cpu_rdata == m_data[f_idx(ma)], "R3", "cpu_rdata", cpu_rdata, m_data[f_idx(ma)]);
    end
  end

  // System-bus responder.
  always @(negedge clk) begin
    if (!rst_n) begin
      sys_ack = 0; sys_rdata = 0; wcnt = 0;
    end else if (sys_ack) begin
      sys_ack = 0; wcnt = 0;
    end else if (sys_as) begin
      wcnt++;
      if (wcnt >= SYS_WAIT) begin
        sys_ack = 1; sys_rdata = pat(sys_addr);
      end
    end else wcnt = 0;
  end

  // Watchdog.
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", wd);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic cpu_access(input logic [15:0] a, input bit w, input logic [15:0] d,
                            input int hold, output logic [15:0] rd, output bit saw_sys,
                            output bit saw_retry, output int lat, output int nterm,
                            output int first_sys, output bit berr_at_drop);
    bit done;
    rd = 0; saw_sys = 0; saw_retry = 0; lat = 0; nterm = 0; first_sys = 0;
    berr_at_drop = 0; done = 0;
    @(negedge clk);
    cpu_addr = a; cpu_wr = w; cpu_wdata = d; cpu_as = 1;
    while (!done) begin
      @(negedge clk);
      lat++;
      if (sys_as && !saw_sys) begin saw_sys = 1; first_sys = lat; end
      if (cpu_berr) begin saw_retry = 1; done = 1; end
      else if (cpu_term) begin nterm++; rd = cpu_rdata; done = 1; end
    end
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (sys_as && !saw_sys) begin saw_sys = 1; first_sys = lat + k + 1; end
      if (cpu_term) nterm++;
      if (cpu_berr) saw_retry = 1;
      berr_at_drop = cpu_berr && cpu_halt;
    end
    cpu_as = 0; cpu_wr = 0;
    @(negedge clk);
    while (cpu_berr) @(negedge clk);
  endtask

  localparam logic [15:0] A = 16'h0010;  // index 0
  localparam logic [15:0] B = 16'h0020;  // index 0, other tag
  localparam logic [15:0] C = 16'h0012;  // index 1
  localparam logic [15:0] D = 16'h0404;  // index 2
  localparam logic [15:0] E = 16'h0016;  // index 3

  initial begin
    logic [15:0] rd;
    bit ss, sr, bd;
    int lat, nt, fs;
    rst_n = 0; early_en = 0; inv_all = 0; cpu_as = 0; cpu_wr = 0;
    cpu_addr = 0; cpu_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!cpu_term && !cpu_berr && !cpu_halt && !sys_as && !sys_wr && sys_addr == 0,
        "R1", "outputs after reset", {cpu_term, cpu_berr, cpu_halt, sys_as}, 0);

    cpu_access(A, 0, 0, 0, rd, ss, sr, lat, nt, fs, bd);
    chk(ss, "R1", "first read misses", ss, 1);
    chk(fs == DEC_LAT + 1, "R4", "miss strobe edge", fs, DEC_LAT + 1);
    chk(rd == pat(A), "R5", "fill data", rd, pat(A));
    cpu_access(A, 0, 0, 0, rd, ss, sr, lat, nt, fs, bd);
    chk(!ss, "R3", "hit keeps strobe low", ss, 0);
    chk(lat == DEC_LAT + 1, "R2", "hit termination edge", lat, DEC_LAT + 1);
    chk(rd == pat(A), "R3", "hit data", rd, pat(A));

    cpu_access(C, 0, 0, 0, rd, ss, sr, lat, nt, fs, bd);
    cpu_access(B, 0, 0, 0, rd, ss, sr, lat, nt, fs, bd);
    chk(ss && rd == pat(B), "R11", "conflict address misses", ss, 1);
    cpu_access(C, 0, 0, 0, rd, ss, sr, lat, nt, fs, bd);
    chk(!ss && rd == pat(C), "R11", "other index survives", ss, 0);
    cpu_access(A, 0, 0, 0, rd, ss, sr, lat, nt, fs, bd);
    chk(ss, "R11", "evicted address misses", ss, 1);

    cpu_access(C, 1, 16'hBEEF, 0, rd, ss, sr, lat, nt, fs, bd);
    chk(ss && nt == 1, "R6", "write hit goes to system", ss, 1);
    cpu_access(C, 0, 0, 0, rd, ss, sr, lat, nt, fs, bd);
    chk(!ss && rd == 16'hBEEF, "R6", "write hit updated word", rd, 16'hBEEF);
    cpu_access(D, 1, 16'h5A5A, 0, rd, ss, sr, lat, nt, fs, bd);
    chk(ss, "R6", "write miss goes to system", ss, 1);
    cpu_access(D, 0, 0, 0, rd, ss, sr, lat, nt, fs, bd);
    chk(ss, "R6", "write miss did not allocate", ss, 1);

    cpu_access(A, 0, 0, 3, rd, ss, sr, lat, nt, fs, bd);
    chk(nt == 1, "R12", "single termination pulse", nt, 1);

    cpu_access(E, 0, 0, 0, rd, ss, sr, lat, nt, fs, bd);  // fill index 3
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
    cpu_access(C, 0, 0, 0, rd, ss, sr, lat, nt, fs, bd);
    chk(lat > LINES, "R7", "access stalled during clear", lat, LINES + 1);
    chk(ss && rd == pat(C), "R7", "cleared line misses", ss, 1);

    @(negedge clk); early_en = 1;
    cpu_access(C, 0, 0, 4, rd, ss, sr, lat, nt, fs, bd);
    chk(lat == EARLY_LAT, "R8", "speculative termination edge", lat, EARLY_LAT);
    chk(!ss && !sr && rd == pat(C), "R8", "speculative hit", {ss, sr}, 0);

    cpu_access(E, 0, 0, 5, rd, ss, sr, lat, nt, fs, bd);
    chk(sr, "R9", "speculative miss retried", sr, 1);
    chk(bd, "R9", "retry held while strobe high", bd, 1);
    chk(!ss, "R9", "no strobe before retry", ss, 0);
    cpu_access(E, 0, 0, 0, rd, ss, sr, lat, nt, fs, bd);
    chk(ss && fs == 1, "R10", "retried access goes out at once", fs, 1);
    chk(!sr && rd == pat(E), "R10", "retried access data", rd, pat(E));
    cpu_access(E, 0, 0, 4, rd, ss, sr, lat, nt, fs, bd);
    chk(!ss && !sr && lat == EARLY_LAT, "R10", "retried line now hits", {ss, sr}, 0);

    cpu_access(A, 1, 16'h1111, 0, rd, ss, sr, lat, nt, fs, bd);
    chk(ss && lat > DEC_LAT + 1, "R8", "write not speculated", lat, DEC_LAT + 2);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule